// File: doc/BRIEF.md
# Cumulative-Checksum Chain Frame Parser

This block sits behind the receive side of a serial daisy chain and parses one read-response frame per transaction. A frame opens with a start byte, a command byte and a two-byte address. A data field follows in which every node on the chain has placed a two-byte reading, back to back, with nothing between the readings. After the data field comes a single two-byte checksum that covers all of the readings together, and the frame closes with an end byte. The block presents each reading on a word port together with a valid strobe and the word's position in the frame. When the end byte arrives it pulses a frame-done strobe that carries two verdicts: whether the checksum matched and whether the closing byte was correct.

The number of nodes is an input that is sampled when a start byte is accepted, so the same instance can serve chains of different lengths. Bytes are offered one per cycle with a valid qualifier, and any cycle without the qualifier is a stall. A byte equal to the start pattern always begins a new frame. The link layer above this block must therefore keep that value out of the payload and the checksum, or remove it from them before they reach the block.

Top module: `chain_frame_parser`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `word_valid`, `frame_done`, `crc_error` and `format_error` are low. A synchronous reset in the middle of a frame abandons it, so the bytes that follow produce no output until a new start byte arrives.
- R2: While no frame is open, every accepted byte other than the start pattern (0xF0 by default) is discarded and produces no output.
- R3: After the start byte, the next three accepted bytes are taken as the command and the address (high byte, then low byte). They produce no word and do not enter the checksum.
- R4: The data field is read as N words of two bytes each, high byte first. For each word, `word_valid` is high for exactly one cycle, namely the cycle after the edge that accepts the word's low byte. At the same time `word_data` carries the word and `word_index` carries its position, counting 0 to N-1 in arrival order.
- R5: The checksum is computed over the data bytes only, in arrival order. It is a 16-bit CRC with polynomial 0x8005, seed 0x0000, no reflection and no final XOR, and each byte is fed into it most significant bit first. The received checksum arrives high byte first. `crc_error` is high together with `frame_done` when the received value differs from the computed one.
- R6: The byte in the end slot is accepted, and `frame_done` then pulses for one cycle after that edge. `format_error` is high with it exactly when that byte is not the end pattern (0x0F by default).
- R7: `node_count` is sampled only when the start byte is accepted. The frame then spans 7 + 2N bytes for every N from 1 to 64, and a change of `node_count` during the frame has no effect on that frame.
- R8: A start byte that arrives while `node_count` is 0 or above 64 opens no frame. It also abandons any open frame, and the bytes that follow produce no output.
- R9: A start byte at any position inside an open frame abandons that frame without a `frame_done`, restarts the checksum from its seed and begins a new frame.
- R10: A cycle with `byte_valid` low changes nothing. Stalls between bytes leave the words, the checksum and the verdicts unchanged, and no output strobe appears in a cycle after an edge at which no byte was accepted.
- R11: `crc_error` and `format_error` are never high without `frame_done`, and `word_valid` and `frame_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | The byte on `byte_data` is accepted at this edge |
| byte_data | input | 8 | Received chain byte |
| node_count | input | 7 | Number of nodes N on the chain, sampled at the start byte |
| word_valid | output | 1 | One-cycle strobe: a data word is on `word_data` |
| word_data | output | 16 | Data word, first received byte in the high half |
| word_index | output | 6 | Position of the word in the frame, starting at 0 |
| frame_done | output | 1 | One-cycle strobe: the end slot was received |
| crc_error | output | 1 | Checksum mismatch, valid with `frame_done` |
| format_error | output | 1 | Wrong end byte, valid with `frame_done` |

## Verification
A wrong field state shows up within a frame. It moves the point where the first word strobe appears, or it shifts the byte pairing of every word, and the scoreboard's word-by-word comparison catches either on the first word after the error. A wrong word counter or a wrong latched node count makes the frame end early or late. That appears as a missing or extra word, or as a `frame_done` arriving at the wrong position in the expected stream. A corrupted accumulator is silent until the end slot, where it shows as a spurious or missing `crc_error`. For that reason, frames with a correct checksum and frames with a flipped checksum are both compared against values computed in the bench.

// File: rtl/chain_frame_pkg.sv
package chain_frame_pkg;

   typedef enum logic [3:0] {
      FLD_IDLE,
      FLD_CMD,
      FLD_ADDR_HI,
      FLD_ADDR_LO,
      FLD_DATA_HI,
      FLD_DATA_LO,
      FLD_SUM_HI,
      FLD_SUM_LO,
      FLD_TAIL
   } field_t;

   typedef struct packed {
      logic restart;
      logic data_hi;
      logic data_lo;
      logic sum_hi;
      logic sum_lo;
      logic tail;
   } field_ctl_t;

   function automatic logic [15:0] mirror16(input logic [15:0] v);
      logic [15:0] r;
      for (int k = 0; k < 16; k++) r[k] = v[15-k];
      return r;
   endfunction

endpackage

// File: rtl/cfp_crc_accum.sv
module cfp_crc_accum #(
   parameter logic [15:0] POLY      = 16'h8005,
   parameter logic [15:0] SEED      = 16'h0000,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        clr,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [15:0] crc
);

   logic [15:0] crc_q;
   logic [15:0] crc_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            crc_nxt = crc_q ^ {din, 8'h00};
            for (int b = 0; b < 8; b++) begin
               crc_nxt = crc_nxt[15] ? ((crc_nxt << 1) ^ POLY) : (crc_nxt << 1);
            end
         end
      end else begin : g_lsb
         localparam logic [15:0] POLY_R = chain_frame_pkg::mirror16(POLY);
         always_comb begin
            crc_nxt = crc_q ^ {8'h00, din};
            for (int b = 0; b < 8; b++) begin
               crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ POLY_R) : (crc_nxt >> 1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) crc_q <= SEED;
      else if (step)  crc_q <= crc_nxt;
   end

   assign crc = crc_q;

endmodule

// File: rtl/cfp_len_track.sv
module cfp_len_track #(
   parameter int MAX_NODES = 64,
   parameter int CNT_W     = $clog2(MAX_NODES + 1),
   parameter int IDX_W     = $clog2(MAX_NODES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] nodes_in,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             last
);

   logic [CNT_W-1:0] nodes_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         nodes_q <= CNT_W'(1);
         idx_q   <= '0;
      end else if (load) begin
         nodes_q <= nodes_in;
         idx_q   <= '0;
      end else if (advance && !last) begin
         idx_q   <= idx_q + IDX_W'(1);
      end
   end

   assign last = (CNT_W'(idx_q) + CNT_W'(1)) == nodes_q;
   assign idx  = idx_q;

endmodule

// File: rtl/cfp_field_seq.sv
module cfp_field_seq
   import chain_frame_pkg::*;
#(
   parameter logic [7:0] START_CODE = 8'hF0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       count_ok,
   input  logic       last_word,
   output field_ctl_t ctl
);

   field_t fld_q, fld_nxt;

   always_comb begin
      ctl     = '0;
      fld_nxt = fld_q;
      if (in_valid) begin
         if (in_byte == START_CODE) begin
            if (count_ok) begin
               ctl.restart = 1'b1;
               fld_nxt     = FLD_CMD;
            end else begin
               fld_nxt     = FLD_IDLE;
            end
         end else begin
            unique case (fld_q)
               FLD_IDLE:    fld_nxt = FLD_IDLE;
               FLD_CMD:     fld_nxt = FLD_ADDR_HI;
               FLD_ADDR_HI: fld_nxt = FLD_ADDR_LO;
               FLD_ADDR_LO: fld_nxt = FLD_DATA_HI;
               FLD_DATA_HI: begin
                  ctl.data_hi = 1'b1;
                  fld_nxt     = FLD_DATA_LO;
               end
               FLD_DATA_LO: begin
                  ctl.data_lo = 1'b1;
                  fld_nxt     = last_word ? FLD_SUM_HI : FLD_DATA_HI;
               end
               FLD_SUM_HI: begin
                  ctl.sum_hi = 1'b1;
                  fld_nxt    = FLD_SUM_LO;
               end
               FLD_SUM_LO: begin
                  ctl.sum_lo = 1'b1;
                  fld_nxt    = FLD_TAIL;
               end
               FLD_TAIL: begin
                  ctl.tail = 1'b1;
                  fld_nxt  = FLD_IDLE;
               end
               default:     fld_nxt = FLD_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) fld_q <= FLD_IDLE;
      else     fld_q <= fld_nxt;
   end

endmodule

// File: rtl/chain_frame_parser.sv
module chain_frame_parser
   import chain_frame_pkg::*;
#(
   parameter int          MAX_NODES     = 64,
   parameter logic [7:0]  START_CODE    = 8'hF0,
   parameter logic [7:0]  END_CODE      = 8'h0F,
   parameter logic [15:0] CRC_POLY      = 16'h8005,
   parameter logic [15:0] CRC_SEED      = 16'h0000,
   parameter bit          CRC_MSB_FIRST = 1'b1,
   localparam int         CNT_W         = $clog2(MAX_NODES + 1),
   localparam int         IDX_W         = $clog2(MAX_NODES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   input  logic [CNT_W-1:0] node_count,
   output logic             word_valid,
   output logic [15:0]      word_data,
   output logic [IDX_W-1:0] word_index,
   output logic             frame_done,
   output logic             crc_error,
   output logic             format_error
);

   if (MAX_NODES < 2) begin : g_bad_nodes
      $error("chain_frame_parser: MAX_NODES must be at least 2");
   end
   if (START_CODE == END_CODE) begin : g_bad_codes
      $error("chain_frame_parser: start and end patterns must differ");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("chain_frame_parser: CRC polynomial must have its constant term set");
   end

   field_ctl_t       ctl;
   logic             count_ok;
   logic             last_word;
   logic [IDX_W-1:0] cur_idx;
   logic [15:0]      crc_acc;
   logic [7:0]       hi_q;
   logic [15:0]      rx_sum_q;

   assign count_ok = (node_count != '0) && (node_count <= CNT_W'(MAX_NODES));

   cfp_field_seq #(
      .START_CODE (START_CODE)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (byte_valid),
      .in_byte   (byte_data),
      .count_ok  (count_ok),
      .last_word (last_word),
      .ctl       (ctl)
   );

   cfp_len_track #(
      .MAX_NODES (MAX_NODES),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W)
   ) u_len (
      .clk      (clk),
      .rst      (rst),
      .load     (ctl.restart),
      .nodes_in (node_count),
      .advance  (ctl.data_lo),
      .idx      (cur_idx),
      .last     (last_word)
   );

   cfp_crc_accum #(
      .POLY      (CRC_POLY),
      .SEED      (CRC_SEED),
      .MSB_FIRST (CRC_MSB_FIRST)
   ) u_crc (
      .clk  (clk),
      .rst  (rst),
      .clr  (ctl.restart),
      .step (ctl.data_hi | ctl.data_lo),
      .din  (byte_data),
      .crc  (crc_acc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         word_valid   <= 1'b0;
         word_data    <= '0;
         word_index   <= '0;
         frame_done   <= 1'b0;
         crc_error    <= 1'b0;
         format_error <= 1'b0;
         hi_q         <= '0;
         rx_sum_q     <= '0;
      end else begin
         word_valid   <= ctl.data_lo;
         frame_done   <= ctl.tail;
         crc_error    <= ctl.tail && (rx_sum_q != crc_acc);
         format_error <= ctl.tail && (byte_data != END_CODE);
         if (ctl.data_hi) hi_q <= byte_data;
         if (ctl.data_lo) begin
            word_data  <= {hi_q, byte_data};
            word_index <= cur_idx;
         end
         if (ctl.sum_hi) rx_sum_q[15:8] <= byte_data;
         if (ctl.sum_lo) rx_sum_q[7:0]  <= byte_data;
      end
   end

endmodule

// File: rtl/chain_frame_parser_chk.sv
module chain_frame_parser_chk #(
   parameter int         MAX_NODES  = 64,
   parameter logic [7:0] START_CODE = 8'hF0,
   parameter logic [7:0] END_CODE   = 8'h0F,
   localparam int        IDX_W      = $clog2(MAX_NODES)
) (
   input logic             clk,
   input logic             rst,
   input logic             byte_valid,
   input logic [7:0]       byte_data,
   input logic             word_valid,
   input logic [IDX_W-1:0] word_index,
   input logic             frame_done,
   input logic             crc_error,
   input logic             format_error
);

   logic [IDX_W:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst) seen_q <= '0;
      else if (byte_valid && byte_data == START_CODE) seen_q <= '0;
      else if (word_valid) seen_q <= seen_q + 1'b1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!word_valid && !frame_done && !crc_error && !format_error));

   a_r11_strobes_apart: assert property (@(posedge clk) disable iff (rst)
      !(word_valid && frame_done));

   a_r11_flags_with_done: assert property (@(posedge clk) disable iff (rst)
      (crc_error || format_error) |-> frame_done);

   a_r10_word_after_byte: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> $past(byte_valid));

   a_r10_done_after_byte: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> $past(byte_valid));

   a_r4_index_order: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> (word_index == seen_q[IDX_W-1:0]));

   a_r6_end_verdict: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> (format_error == ($past(byte_data) != END_CODE)));

endmodule

bind chain_frame_parser chain_frame_parser_chk #(
   .MAX_NODES  (MAX_NODES),
   .START_CODE (START_CODE),
   .END_CODE   (END_CODE)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .byte_valid   (byte_valid),
   .byte_data    (byte_data),
   .word_valid   (word_valid),
   .word_index   (word_index),
   .frame_done   (frame_done),
   .crc_error    (crc_error),
   .format_error (format_error)
);

// File: tb/chain_frame_parser_test.sv
`timescale 1ns/1ps
module chain_frame_parser_test;

   localparam logic [7:0] SOF = 8'hF0;
   localparam logic [7:0] EOF = 8'h0F;

   typedef struct {
      bit          is_done;
      logic [15:0] data;
      int          idx;
      bit          cerr;
      bit          ferr;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic [6:0]  node_count = 7'd4;
   logic        word_valid;
   logic [15:0] word_data;
   logic [5:0]  word_index;
   logic        frame_done;
   logic        crc_error;
   logic        format_error;

   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";
   exp_t  sb[$];
   logic [15:0] wbuf [0:63];

   always #2.5 clk = ~clk;

   chain_frame_parser uut (
      .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
      .node_count(node_count), .word_valid(word_valid), .word_data(word_data),
      .word_index(word_index), .frame_done(frame_done), .crc_error(crc_error),
      .format_error(format_error)
   );

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c;
      logic [7:0]  b;
      c = 16'h0000;
      for (int w = 0; w < n; w++) begin
         for (int h = 0; h < 2; h++) begin
            b = (h == 0) ? wbuf[w][15:8] : wbuf[w][7:0];
            c = c ^ {b, 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
         end
      end
      return c;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (word_valid && frame_done) begin
            checks++; failures++;
            $display("FAIL R11: word_valid and frame_done together got 1 exp 0");
         end
         if (!frame_done && (crc_error || format_error)) begin
            checks++; failures++;
            $display("FAIL R11: flag without frame_done got crc=%0b fmt=%0b exp 0", crc_error, format_error);
         end
         if (word_valid || frame_done) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
               failures++;
               $display("FAIL %s: unexpected strobe got word=%0b done=%0b exp none", cur_req, word_valid, frame_done);
            end else begin
               e = sb.pop_front();
               if (word_valid && !e.is_done) begin
                  if (word_data !== e.data || word_index !== e.idx[5:0]) begin
                     failures++;
                     $display("FAIL %s: word got %h@%0d exp %h@%0d", e.req, word_data, word_index, e.data, e.idx);
                  end
               end else if (frame_done && e.is_done) begin
                  if (crc_error !== e.cerr || format_error !== e.ferr) begin
                     failures++;
                     $display("FAIL %s: verdict got crc=%0b fmt=%0b exp crc=%0b fmt=%0b",
                              e.req, crc_error, format_error, e.cerr, e.ferr);
                  end
               end else begin
                  failures++;
                  $display("FAIL %s: strobe kind got done=%0b exp done=%0b", e.req, frame_done, e.is_done);
               end
            end
         end
      end
   end

   task automatic send_byte(input logic [7:0] b, input int gap);
      byte_valid = 1'b1;
      byte_data  = b;
      @(posedge clk); #1;
      byte_valid = 1'b0;
      byte_data  = 8'h5C;
      repeat (gap) begin @(posedge clk); #1; end
   endtask

   task automatic push_word(input int i, input string req);
      exp_t e;
      e.is_done = 1'b0; e.data = wbuf[i]; e.idx = i; e.cerr = 1'b0; e.ferr = 1'b0; e.req = req;
      sb.push_back(e);
   endtask

   task automatic fill(input int n, input logic [15:0] base);
      for (int i = 0; i < n; i++) wbuf[i] = base + 16'(i) * 16'h0101;
   endtask

   task automatic send_frame(input int n, input logic [7:0] cmd, input logic [15:0] addr,
                             input bit bad_crc, input logic [7:0] endb, input int gap,
                             input int alt_cnt, input string req);
      logic [15:0] c, tx;
      exp_t e;
      c = ref_crc(n);
      while (c[15:8] == SOF || c[7:0] == SOF) begin
         wbuf[n-1] = wbuf[n-1] + 16'h0001;
         c = ref_crc(n);
      end
      tx = bad_crc ? (c ^ 16'h0101) : c;
      if (tx[15:8] == SOF || tx[7:0] == SOF) tx = tx ^ 16'h0202;
      for (int i = 0; i < n; i++) push_word(i, req);
      e.is_done = 1'b1; e.data = 16'h0; e.idx = 0; e.cerr = bad_crc;
      e.ferr = (endb != EOF); e.req = req;
      sb.push_back(e);
      cur_req = req;
      node_count = 7'(n);
      send_byte(SOF, gap);
      if (alt_cnt >= 0) node_count = 7'(alt_cnt);
      send_byte(cmd, gap);
      send_byte(addr[15:8], gap);
      send_byte(addr[7:0], gap);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i][15:8], gap);
         send_byte(wbuf[i][7:0], gap);
      end
      send_byte(tx[15:8], gap);
      send_byte(tx[7:0], gap);
      send_byte(endb, gap);
   endtask

   task automatic expect_quiet(input string req);
      repeat (4) @(posedge clk);
      #1;
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL %s: pending expected items got %0d exp 0", req, sb.size());
      end
   endtask

   task automatic check_idle_outputs(input string req);
      checks++;
      if (word_valid !== 1'b0 || frame_done !== 1'b0 || crc_error !== 1'b0 || format_error !== 1'b0) begin
         failures++;
         $display("FAIL %s: outputs got %b%b%b%b exp 0000", req, word_valid, frame_done, crc_error, format_error);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL %s: watchdog expired got hang exp completion", cur_req);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle_outputs("R1");
      @(posedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      check_idle_outputs("R1");
      @(posedge clk); #1;

      // R2: garbage while idle
      cur_req = "R2";
      send_byte(8'h00, 0); send_byte(EOF, 1); send_byte(8'h33, 0); send_byte(8'hA5, 0);
      expect_quiet("R2");

      // R3 R4 R5: four-node frame, header values nonzero
      wbuf[0] = 16'hA510; wbuf[1] = 16'hA520; wbuf[2] = 16'hA530; wbuf[3] = 16'hA540;
      send_frame(4, 8'h02, 16'h1234, 1'b0, EOF, 0, -1, "R4");
      expect_quiet("R4");
      wbuf[0] = 16'hA510; wbuf[1] = 16'hA520; wbuf[2] = 16'hA530; wbuf[3] = 16'hA540;
      send_frame(4, 8'h7B, 16'hEEDD, 1'b0, EOF, 0, -1, "R3");
      expect_quiet("R3");

      // R10: same data with stalls
      fill(4, 16'h1200);
      send_frame(4, 8'h02, 16'h0001, 1'b0, EOF, 2, -1, "R10");
      expect_quiet("R10");

      // R5: corrupted checksum
      fill(3, 16'h2211);
      send_frame(3, 8'h02, 16'h0002, 1'b1, EOF, 0, -1, "R5");
      expect_quiet("R5");

      // R6: wrong end byte
      fill(2, 16'h3344);
      send_frame(2, 8'h02, 16'h0003, 1'b0, 8'h55, 1, -1, "R6");
      expect_quiet("R6");

      // R7: boundaries and mid-frame count change
      fill(1, 16'h0102);
      send_frame(1, 8'h02, 16'h0004, 1'b0, EOF, 0, -1, "R7");
      fill(64, 16'h1200);
      send_frame(64, 8'h02, 16'h0005, 1'b0, EOF, 0, -1, "R7");
      fill(5, 16'h4000);
      send_frame(5, 8'h02, 16'h0006, 1'b0, EOF, 0, 2, "R7");
      expect_quiet("R7");

      // R8: out-of-range counts
      cur_req = "R8";
      node_count = 7'd0;
      send_byte(SOF, 0); send_byte(8'h02, 0); send_byte(8'h00, 0); send_byte(8'h01, 0);
      send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0); send_byte(8'h44, 0);
      send_byte(EOF, 0);
      node_count = 7'd65;
      send_byte(SOF, 0); send_byte(8'h02, 0); send_byte(8'h00, 0); send_byte(8'h01, 0);
      send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0); send_byte(8'h44, 0);
      send_byte(EOF, 0);
      expect_quiet("R8");

      // R9: abort in data field, then full frame
      fill(4, 16'h1300);
      cur_req = "R9";
      push_word(0, "R9"); push_word(1, "R9");
      node_count = 7'd4;
      send_byte(SOF, 0); send_byte(8'h02, 0); send_byte(8'h00, 0); send_byte(8'h07, 0);
      send_byte(wbuf[0][15:8], 0); send_byte(wbuf[0][7:0], 0);
      send_byte(wbuf[1][15:8], 0); send_byte(wbuf[1][7:0], 0);
      send_byte(wbuf[2][15:8], 0);
      fill(3, 16'h2500);
      send_frame(3, 8'h02, 16'h0008, 1'b0, EOF, 0, -1, "R9");
      expect_quiet("R9");

      // R9: abort in checksum slot
      fill(2, 16'h1700);
      push_word(0, "R9"); push_word(1, "R9");
      node_count = 7'd2;
      send_byte(SOF, 0); send_byte(8'h02, 0); send_byte(8'h00, 0); send_byte(8'h09, 0);
      for (int i = 0; i < 2; i++) begin
         send_byte(wbuf[i][15:8], 0); send_byte(wbuf[i][7:0], 0);
      end
      send_byte(8'h12, 0);
      fill(2, 16'h1800);
      send_frame(2, 8'h02, 16'h000A, 1'b0, EOF, 0, -1, "R9");
      expect_quiet("R9");

      // R1: reset mid-frame abandons it
      cur_req = "R1";
      node_count = 7'd2;
      send_byte(SOF, 0); send_byte(8'h02, 0); send_byte(8'h00, 0);
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      send_byte(8'h01, 0); send_byte(8'h21, 0); send_byte(8'h22, 0);
      send_byte(8'h23, 0); send_byte(8'h24, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
      send_byte(EOF, 0);
      expect_quiet("R1");

      // R11: one more clean frame after everything
      fill(3, 16'h0A0B);
      send_frame(3, 8'h02, 16'h000C, 1'b0, EOF, 1, -1, "R11");
      expect_quiet("R11");

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule